// File: doc/BRIEF.md
# Clock Controller Register File

This block is the software-visible register bank of a reset-and-clock controller. A processor reaches it through a 32-bit read/write port in the usual two-phase style: select, then enable. It stores the oscillator enable bits, the system clock source switch, four bus prescaler fields and a set of ready-interrupt enables. It drives the selected source code and the prescaler fields straight to a downstream clock-enable generator.

No status bit is stored. Every ready bit and the source status field are wired mirrors of the control bits beside them. Each interrupt flag reads the same as its matching enable. A write of 1 to a bit of the clear register drops that enable, and the flag drops with it. Any write to the control, source or prescaler registers produces a single-cycle `config_changed` pulse, so the generator knows it must reload its dividers.

The port has no wait states and no back-pressure. A transfer always completes in its access cycle. Every pin is a plain control or status signal, so no valid/ready handshake applies.

Top module: `clk_ctrl_regs`

## Requirements
- R1: After reset the control word at offset 0x00 reads 0x0000_0500. The words at 0x1C, 0x20, 0x24 and 0x50 read 0.
- R2: In the control word, bits 8, 16, 20 and 24 are writable. Read-only bit 10 equals bit 8, bit 17 equals bit 16, and bit 25 equals bit 24. Every other bit reads 0, so a write of all ones reads back 0x0313_0500.
- R3: At 0x1C, bits 1:0 hold the source code and bits 3:2 read back the same code. The code drives `sys_src`, with 0 selecting the internal 16 MHz oscillator, 2 the halved external oscillator and 3 the PLL R output. Bits 31:4 read 0.
- R4: At 0x20 the 3-bit prescalers sit in bits 2:0 (`ahb_pre`), 6:4 (`apb1_pre`) and 10:8 (`apb2_pre`). At 0x24 bits 6:4 hold `apb7_pre`. Control bit 20 drives `hse_div2`. All other bits of both words read 0.
- R5: The interrupt enable word at 0x50 keeps only bits 0, 1, 3, 4 and 6, which are the low-speed internal, low-speed external, internal 16 MHz, external and PLL ready enables.
- R6: The flag word at 0x54 reads equal to the enable word. Its bit 10, the clock security flag, always reads 0, and writes to 0x54 change nothing.
- R7: A 1 written to bit 0, 1, 3, 4 or 6 of the clear word at 0x58 resets the same bit of the enable word. A 0 leaves that bit as it was. The clear word reads 0.
- R8: Reads at unmapped offsets return 0, and writes there change no register.
- R9: `config_changed` is high for exactly the one cycle after the write edge of a write to 0x00, 0x1C, 0x20 or 0x24. A write to any other offset does not raise it.
- R10: A register changes only at a clock edge where `psel`, `penable` and `pwrite` are all high. A setup phase alone writes nothing.
- R11: `prdata` is registered. It loads at the edge of a read access and holds its value until the next read access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Block select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Registered read data |
| sys_src | output | 2 | Selected system clock source code |
| hse_div2 | output | 1 | Halve the external oscillator clock |
| ahb_pre | output | 3 | AHB prescaler code |
| apb1_pre | output | 3 | APB1 prescaler code |
| apb2_pre | output | 3 | APB2 prescaler code |
| apb7_pre | output | 3 | APB7 prescaler code |
| config_changed | output | 1 | One-cycle pulse after a clock configuration write |

## Verification
The assertions check three things on every cycle. First, `config_changed` only ever follows a write that hit a clock configuration word. Second, the source code and `prdata` hold still when no transfer targets them. Third, the clear word removes exactly the enable bits written as 1 and touches no others. The bench scenarios are needed for the rest: the exact reset words, the mirroring of ready and status bits, the masking of reserved bits, the flag word reading as the enable word, and the zero reads at the clear word and at unmapped offsets.

// File: rtl/clkreg_pkg.sv
package clkreg_pkg;
  localparam logic [11:0] OFF_CTL  = 12'h000;
  localparam logic [11:0] OFF_SRC  = 12'h01C;
  localparam logic [11:0] OFF_PRE  = 12'h020;
  localparam logic [11:0] OFF_PRE7 = 12'h024;
  localparam logic [11:0] OFF_IEN  = 12'h050;
  localparam logic [11:0] OFF_IFL  = 12'h054;
  localparam logic [11:0] OFF_ICL  = 12'h058;

  // index of each clock configuration word in the select vector
  localparam int CW_CTL  = 0;
  localparam int CW_SRC  = 1;
  localparam int CW_PRE  = 2;
  localparam int CW_PRE7 = 3;
  localparam int CW_N    = 4;

  localparam int PRE_W = 3;
  localparam int PRE_N = 4;

  // ready-interrupt bits kept by enable/flag/clear
  localparam logic [31:0] IRQ_MASK = 32'h0000_005B;

  typedef enum logic [1:0] {
    SRC_HSI16    = 2'd0,
    SRC_RESERVED = 2'd1,
    SRC_HSE_HALF = 2'd2,
    SRC_PLL_R    = 2'd3
  } sysclk_src_e;

  // prescaler k: which word holds it and at which bit it starts
  function automatic int pre_word(input int k);
    return (k == 3) ? CW_PRE7 : CW_PRE;
  endfunction

  function automatic int pre_lsb(input int k);
    return (k == 3) ? 4 : 4 * k;
  endfunction
endpackage

// File: rtl/clkreg_ctrl.sv
module clkreg_ctrl
  import clkreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CW_N-1:0]   wsel,
  input  logic [31:0]       wdata,
  output logic [31:0]       rd_word [CW_N],
  output sysclk_src_e       sys_src,
  output logic              hse_div2,
  output logic [PRE_W-1:0]  pre [PRE_N],
  output logic              cfg_changed
);
  logic hsi_on, hse_on, pll_on;
  sysclk_src_e src_q;
  logic unused_wbits;
  assign unused_wbits = ^wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hsi_on   <= 1'b1;
      hse_on   <= 1'b0;
      hse_div2 <= 1'b0;
      pll_on   <= 1'b0;
    end else if (we && wsel[CW_CTL]) begin
      hsi_on   <= wdata[8];
      hse_on   <= wdata[16];
      hse_div2 <= wdata[20];
      pll_on   <= wdata[24];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     src_q <= SRC_HSI16;
    else if (we && wsel[CW_SRC])    src_q <= sysclk_src_e'(wdata[1:0]);
  end
  assign sys_src = src_q;

  for (genvar k = 0; k < PRE_N; k++) begin : g_pre
    localparam int W = pre_word(k);
    localparam int L = pre_lsb(k);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               pre[k] <= '0;
      else if (we && wsel[W])   pre[k] <= wdata[L +: PRE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_changed <= 1'b0;
    else        cfg_changed <= we && (|wsel);
  end

  always_comb begin
    for (int w = 0; w < CW_N; w++) rd_word[w] = '0;
    rd_word[CW_CTL][8]  = hsi_on;
    rd_word[CW_CTL][10] = hsi_on;
    rd_word[CW_CTL][16] = hse_on;
    rd_word[CW_CTL][17] = hse_on;
    rd_word[CW_CTL][20] = hse_div2;
    rd_word[CW_CTL][24] = pll_on;
    rd_word[CW_CTL][25] = pll_on;
    rd_word[CW_SRC][1:0] = src_q;
    rd_word[CW_SRC][3:2] = src_q;
    for (int k = 0; k < PRE_N; k++)
      rd_word[pre_word(k)][pre_lsb(k) +: PRE_W] = pre[k];
  end

  // R9: pulse only after a write that hit a configuration word
  p_pulse_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_changed |-> $past(we && (|wsel)));

  // R10: source code holds unless its word is written
  p_src_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && wsel[CW_SRC]) |=> $stable(sys_src));
endmodule

// File: rtl/clkreg_irq.sv
module clkreg_irq
  import clkreg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we_en,
  input  logic        we_clr,
  input  logic [31:0] wdata,
  output logic [31:0] en_word,
  output logic [31:0] flag_word
);
  logic [31:0] en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_q <= '0;
    else if (we_en)  en_q <= wdata & IRQ_MASK;
    else if (we_clr) en_q <= en_q & ~(wdata & IRQ_MASK);
  end

  assign en_word   = en_q;
  // security flag (bit 10) is never set: mask keeps it at 0
  assign flag_word = en_q & IRQ_MASK;

  // R7: every enable bit written as 1 to the clear word is 0 afterwards
  p_clear_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    we_clr |=> ((en_q & $past(wdata & IRQ_MASK)) == 32'd0));

  // R7: bits written as 0 to the clear word keep their value
  p_clear_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    we_clr |=> ((en_q & ~$past(wdata)) == ($past(en_q) & ~$past(wdata))));
endmodule

// File: rtl/clk_ctrl_regs.sv
module clk_ctrl_regs
  import clkreg_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic [1:0]        sys_src,
  output logic              hse_div2,
  output logic [2:0]        ahb_pre,
  output logic [2:0]        apb1_pre,
  output logic [2:0]        apb2_pre,
  output logic [2:0]        apb7_pre,
  output logic              config_changed
);
  localparam int WA = ADDR_W - 2;

  logic wr, rd;
  logic [CW_N-1:0] cw_sel;
  logic hit_ien, hit_ifl, hit_icl;
  logic [31:0] cw_rd [CW_N];
  logic [31:0] en_word, flag_word, rd_mux;
  logic [PRE_W-1:0] pre [PRE_N];
  sysclk_src_e src;
  logic unused_lsb;
  assign unused_lsb = ^paddr[1:0];

  assign wr = psel && penable && pwrite;
  assign rd = psel && penable && !pwrite;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [11:0] off);
    return a[ADDR_W-1:2] == off[ADDR_W-1:2];
  endfunction

  assign cw_sel[CW_CTL]  = hit(paddr, OFF_CTL);
  assign cw_sel[CW_SRC]  = hit(paddr, OFF_SRC);
  assign cw_sel[CW_PRE]  = hit(paddr, OFF_PRE);
  assign cw_sel[CW_PRE7] = hit(paddr, OFF_PRE7);
  assign hit_ien = hit(paddr, OFF_IEN);
  assign hit_ifl = hit(paddr, OFF_IFL);
  assign hit_icl = hit(paddr, OFF_ICL);

  clkreg_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .we(wr), .wsel(cw_sel), .wdata(pwdata),
    .rd_word(cw_rd), .sys_src(src), .hse_div2(hse_div2), .pre(pre),
    .cfg_changed(config_changed)
  );

  clkreg_irq u_irq (
    .clk(clk), .rst_n(rst_n), .we_en(wr && hit_ien), .we_clr(wr && hit_icl),
    .wdata(pwdata), .en_word(en_word), .flag_word(flag_word)
  );

  assign sys_src  = src;
  assign ahb_pre  = pre[0];
  assign apb1_pre = pre[1];
  assign apb2_pre = pre[2];
  assign apb7_pre = pre[3];

  always_comb begin
    rd_mux = '0;
    for (int w = 0; w < CW_N; w++)
      if (cw_sel[w]) rd_mux = cw_rd[w];
    if (hit_ien) rd_mux = en_word;
    if (hit_ifl) rd_mux = flag_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  prdata <= '0;
    else if (rd) prdata <= rd_mux;
  end

  // R11: read data holds between read accesses
  p_prdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(prdata));

  // R9: no pulse after a write to the interrupt words
  p_no_pulse_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && (hit_ien || hit_icl || hit_ifl)) |=> !config_changed);

  initial assert (WA >= 7) else $error("ADDR_W too small for register map");
endmodule

// File: tb/tb_clk_ctrl_regs.sv
module tb_clk_ctrl_regs;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 33;
  // {write, addr, data/expected, req}
  localparam logic [80:0] VEC [NV] = '{
    {1'b0, 12'h000, 32'h0000_0500, 32'h0, 4'd1},  // R1
    {1'b0, 12'h01C, 32'h0,         32'h0, 4'd1},  // R1
    {1'b0, 12'h020, 32'h0,         32'h0, 4'd1},  // R1
    {1'b0, 12'h024, 32'h0,         32'h0, 4'd1},  // R1
    {1'b0, 12'h050, 32'h0,         32'h0, 4'd1},  // R1
    {1'b1, 12'h000, 32'hFFFF_FFFF, 32'h0, 4'd2},
    {1'b0, 12'h000, 32'h0313_0500, 32'h0, 4'd2},  // R2
    {1'b1, 12'h000, 32'h0010_0000, 32'h0, 4'd2},
    {1'b0, 12'h000, 32'h0010_0000, 32'h0, 4'd2},  // R2
    {1'b1, 12'h01C, 32'hFFFF_FFFF, 32'h0, 4'd3},
    {1'b0, 12'h01C, 32'h0000_000F, 32'h0, 4'd3},  // R3
    {1'b1, 12'h01C, 32'h0000_0002, 32'h0, 4'd3},
    {1'b0, 12'h01C, 32'h0000_000A, 32'h0, 4'd3},  // R3
    {1'b1, 12'h020, 32'hFFFF_FFFF, 32'h0, 4'd4},
    {1'b0, 12'h020, 32'h0000_0777, 32'h0, 4'd4},  // R4
    {1'b1, 12'h020, 32'h0000_0615, 32'h0, 4'd4},
    {1'b0, 12'h020, 32'h0000_0615, 32'h0, 4'd4},  // R4
    {1'b1, 12'h024, 32'hFFFF_FFFF, 32'h0, 4'd4},
    {1'b0, 12'h024, 32'h0000_0070, 32'h0, 4'd4},  // R4
    {1'b1, 12'h050, 32'hFFFF_FFFF, 32'h0, 4'd5},
    {1'b0, 12'h050, 32'h0000_005B, 32'h0, 4'd5},  // R5
    {1'b0, 12'h054, 32'h0000_005B, 32'h0, 4'd6},  // R6
    {1'b1, 12'h054, 32'h0,         32'h0, 4'd6},
    {1'b0, 12'h054, 32'h0000_005B, 32'h0, 4'd6},  // R6
    {1'b1, 12'h058, 32'h0,         32'h0, 4'd7},
    {1'b0, 12'h050, 32'h0000_005B, 32'h0, 4'd7},  // R7 zero is no-op
    {1'b1, 12'h058, 32'h0000_0048, 32'h0, 4'd7},
    {1'b0, 12'h050, 32'h0000_0013, 32'h0, 4'd7},  // R7
    {1'b0, 12'h054, 32'h0000_0013, 32'h0, 4'd6},  // R6
    {1'b0, 12'h058, 32'h0,         32'h0, 4'd7},  // R7
    {1'b1, 12'h03C, 32'hFFFF_FFFF, 32'h0, 4'd8},
    {1'b0, 12'h03C, 32'h0,         32'h0, 4'd8},  // R8
    {1'b0, 12'h000, 32'h0010_0000, 32'h0, 4'd8}   // R8
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [9:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic [1:0] sys_src;
  logic hse_div2, config_changed;
  logic [2:0] ahb_pre, apb1_pre, apb2_pre, apb7_pre;
  int n_chk = 0, n_fail = 0;
  logic pulse_a, pulse_b;

  always #(CLK_PERIOD/2) clk = ~clk;

  clk_ctrl_regs #(.ADDR_W(10)) dut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .sys_src(sys_src),
    .hse_div2(hse_div2), .ahb_pre(ahb_pre), .apb1_pre(apb1_pre),
    .apb2_pre(apb2_pre), .apb7_pre(apb7_pre), .config_changed(config_changed)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // pulse_a / pulse_b: config_changed one and two cycles after the write edge
  task automatic apb_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a[9:0]; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pulse_a = config_changed;
    @(negedge clk); pulse_b = config_changed;
  endtask

  task automatic apb_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a[9:0];
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; d = prdata;
  endtask

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R1 prdata at reset", prdata, 32'h0);
    check("R3 sys_src at reset", {30'b0, sys_src}, 32'h0);
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][80]) apb_write(VEC[i][79:68], VEC[i][67:36]);
      else begin
        apb_read(VEC[i][79:68], r);
        check($sformatf("R%0d table row %0d", VEC[i][3:0], i), r, VEC[i][67:36]);
      end
    end
    // R3 R4 outputs after table
    check("R3 sys_src", {30'b0, sys_src}, 32'd2);
    check("R4 hse_div2", {31'b0, hse_div2}, 32'd1);
    check("R4 ahb_pre", {29'b0, ahb_pre}, 32'd5);
    check("R4 apb1_pre", {29'b0, apb1_pre}, 32'd1);
    check("R4 apb2_pre", {29'b0, apb2_pre}, 32'd6);
    check("R4 apb7_pre", {29'b0, apb7_pre}, 32'd7);
    // R10: setup phase only, held for several cycles
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = 10'h020; pwdata = 32'h0;
    repeat (3) @(negedge clk);
    psel = 0;
    check("R10 setup-only no pulse", {31'b0, config_changed}, 32'd0);
    apb_read(12'h020, r);
    check("R10 setup-only no write", r, 32'h0000_0615);
    // R9 pulse on config write, none on interrupt write
    apb_write(12'h020, 32'h0000_0123);
    check("R9 pulse high", {31'b0, pulse_a}, 32'd1);
    check("R9 pulse one cycle", {31'b0, pulse_b}, 32'd0);
    apb_write(12'h000, 32'h0000_0100);
    check("R9 pulse on control write", {31'b0, pulse_a}, 32'd1);
    apb_write(12'h050, 32'h0000_0001);
    check("R9 no pulse on irq write", {31'b0, pulse_a}, 32'd0);
    // R11 hold across idle and write
    apb_read(12'h000, r);
    check("R11 read control", r, 32'h0000_0500);
    apb_write(12'h01C, 32'h3);
    repeat (2) @(negedge clk);
    check("R11 prdata holds", prdata, 32'h0000_0500);
    check("R3 PLL source", {30'b0, sys_src}, 32'd3);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule